// File: doc/BRIEF.md
# Bit-Strobed Serial Register Master

This block drives a small serial clock chip that exposes its registers through one shared, bidirectional data wire and three active-low control lines: a select, a write strobe and a read strobe. Each bit crosses the wire in its own select-and-strobe cycle. The host hands the block one request at a time. A request carries a 4-bit register address, an 8-bit value, a read flag and a command flag. The block then serialises the transfer on the pins.

Every access starts with the address nibble, least-significant bit first, sent with write strobes. A register write then sends the 8-bit value, also least-significant bit first. A command sends only the nibble. A read turns the data wire around and collects 8 bits with read strobes, shifting each one in from the top so that the first bit received becomes bit 0. Pulse widths and the gap between bits are given in nanoseconds and converted to whole system clock cycles from the clock frequency parameter, always rounding up. The pad itself stays outside the block: the block provides a drive value, an output enable and a sampled input.

Top module: `srm_serial_master`

## Requirements
- R1: After reset and whenever no request is in flight, `cs_n`, `wr_n` and `rd_n` are high, `dq_oe` is low, `busy` is low and `done` is low.
- R2: Every access begins with exactly 4 write-strobed bits that carry `req_addr` least-significant bit first (bit 0 on the first strobe).
- R3: A register write (`req_read`=0, `req_cmd`=0) follows the address with 8 write-strobed bits carrying `req_wdata` least-significant bit first, for 12 write strobes and no read strobe.
- R4: A command (`req_cmd`=1) produces only the 4 address strobes and no read strobe, whatever the values of `req_wdata` and `req_read`.
- R5: A read (`req_read`=1, `req_cmd`=0) produces 4 address write strobes and then 8 read strobes. The n-th sampled bit becomes bit n-1 of `rdata`. `rdata` is valid in the cycle in which `done` is high and changes only when a read completes.
- R6: For a written bit, `dq_oe` is high and `dq_out` is stable for the whole time `wr_n` is low. `cs_n` and `wr_n` fall in the same cycle, and `cs_n` is still low in the cycle in which `wr_n` rises. `cs_n` rises one cycle later.
- R7: For a read bit, `dq_oe` is low. `cs_n` and `rd_n` fall together, stay low for 2×N_PULSE cycles and rise together. `dq_in` is sampled at the clock edge that ends the N_PULSE-th low cycle.
- R8: Between consecutive bit cycles of one access, `cs_n` stays high for exactly N_GAP+1 cycles: the gap plus one setup cycle in which the data line is prepared.
- R9: A request is taken only while `busy` is low. Requests that arrive while `busy` is high have no effect. Completion is marked by a single-cycle `done` pulse, during which `busy` is already low.
- R10: N_PULSE = ceil(CLK_HZ×PULSE_NS/10^9) and N_GAP = ceil(CLK_HZ×GAP_NS/10^9), each at least 1. A write strobe is low for exactly N_PULSE cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_addr | input | ADDR_W | Register address, sent first |
| req_wdata | input | DATA_W | Value for a register write |
| req_read | input | 1 | 1 = read the register |
| req_cmd | input | 1 | 1 = address-only command |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Byte collected by the last read |
| cs_n | output | 1 | Active-low chip select |
| wr_n | output | 1 | Active-low write strobe |
| rd_n | output | 1 | Active-low read strobe |
| dq_out | output | 1 | Value to drive on the data wire |
| dq_oe | output | 1 | Drive enable for the data wire |
| dq_in | input | 1 | Value sampled from the data wire |

## Verification
The bench's slave model presents the correct read bit only during the single cycle before the intended sample edge and the inverted bit at every other time. A master that samples one cycle early or late therefore returns the complement of the expected byte. Each strobe's low time and each inter-bit high time are measured against the rounded-up cycle counts, so a truncating conversion or a missing setup cycle shows up as an off-by-one width. The command case drives a full data byte with the read flag set, so a design that ignores the command flag produces 12 strobes or read strobes. A second request held during a busy write checks that the captured bit stream and the strobe count are unchanged and that no new access starts afterwards.

// File: rtl/srm_pkg.sv
package srm_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_LOW1,
      PH_LOW2,
      PH_RELEASE,
      PH_GAP
   } bit_phase_e;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_LAUNCH,
      FR_RUN
   } frame_state_e;

   // whole clock cycles covering a span in nanoseconds, rounded up, minimum 1
   function automatic int unsigned ns_to_cycles(longint unsigned hz, longint unsigned ns);
      longint unsigned c;
      c = (hz * ns + 64'd999_999_999) / 64'd1_000_000_000;
      return (c == 64'd0) ? 32'd1 : 32'(c);
   endfunction

endpackage

// File: rtl/srm_tick_timer.sv
module srm_tick_timer #(
   parameter int unsigned MAX_LOAD = 1,
   parameter int unsigned CNT_W    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   generate
      if (MAX_LOAD == 0) begin : g_no_count
         // every interval is one cycle: no counter needed
         logic unused_in;
         assign unused_in = ^{load, load_val, clk, rst_n};
         assign expired   = 1'b1;
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (load)           cnt_q <= load_val;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign expired = (cnt_q == '0);
      end
   endgenerate

endmodule

// File: rtl/srm_bit_phy.sv
module srm_bit_phy
   import srm_pkg::*;
#(
   parameter int unsigned N_PULSE = 1,
   parameter int unsigned N_GAP   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic is_read,
   output logic bit_done,
   output logic sample_en,
   output logic cs_n,
   output logic wr_n,
   output logic rd_n
);

   localparam int unsigned MAXL  = ((N_PULSE > N_GAP) ? N_PULSE : N_GAP) - 1;
   localparam int unsigned CNT_W = (MAXL < 1) ? 1 : $clog2(MAXL + 1);

   bit_phase_e       phase_q, phase_d;
   logic             t_load, t_expired;
   logic [CNT_W-1:0] t_val;

   srm_tick_timer #(.MAX_LOAD(MAXL), .CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   always_comb begin
      phase_d = phase_q;
      t_load  = 1'b0;
      t_val   = '0;
      unique case (phase_q)
         PH_IDLE:  if (start) phase_d = PH_SETUP;
         PH_SETUP: begin
            phase_d = PH_LOW1;
            t_load  = 1'b1;
            t_val   = CNT_W'(N_PULSE - 1);
         end
         PH_LOW1: if (t_expired) begin
            if (is_read) begin
               phase_d = PH_LOW2;
               t_load  = 1'b1;
               t_val   = CNT_W'(N_PULSE - 1);
            end else begin
               phase_d = PH_RELEASE;
            end
         end
         PH_LOW2: if (t_expired) begin
            phase_d = PH_GAP;
            t_load  = 1'b1;
            t_val   = CNT_W'(N_GAP - 1);
         end
         PH_RELEASE: begin
            phase_d = PH_GAP;
            t_load  = 1'b1;
            t_val   = CNT_W'(N_GAP - 1);
         end
         PH_GAP: if (t_expired) phase_d = start ? PH_SETUP : PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign bit_done  = (phase_q == PH_GAP) && t_expired;
   assign sample_en = (phase_q == PH_LOW1) && t_expired && is_read;
   assign cs_n = !((phase_q == PH_LOW1) || (phase_q == PH_LOW2) || (phase_q == PH_RELEASE));
   assign wr_n = !(!is_read && (phase_q == PH_LOW1));
   assign rd_n = !(is_read && ((phase_q == PH_LOW1) || (phase_q == PH_LOW2)));

   // R6: a write strobe only ever appears under an active select
   a_r6_wr_under_cs : assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> !cs_n)
      else $error("write strobe without select");
   // R7: a read strobe only ever appears under an active select
   a_r7_rd_under_cs : assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !cs_n)
      else $error("read strobe without select");
   // R6: the two strobes never overlap
   a_r6_strobe_excl : assert property (@(posedge clk) disable iff (!rst_n) !(!wr_n && !rd_n))
      else $error("both strobes low");
   // R6: the select is never released while the write strobe is still low
   a_r6_wr_first : assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_n) |-> $past(wr_n))
      else $error("select released before write strobe");

endmodule

// File: rtl/srm_frame_ctrl.sv
module srm_frame_ctrl
   import srm_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_read,
   input  logic              req_cmd,
   input  logic              dq_in,
   input  logic              bit_done,
   input  logic              sample_en,
   output logic              start,
   output logic              is_read,
   output logic              dq_out,
   output logic              dq_oe,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned TOT   = ADDR_W + DATA_W;
   localparam int unsigned IDX_W = $clog2(TOT + 1);

   frame_state_e      st_q;
   logic [TOT-1:0]    shreg_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rd_kind_q, cmd_q, done_q;
   logic [DATA_W-1:0] rx_q, rdata_q;
   logic              last_bit, in_data;

   assign last_bit = (idx_q == (cmd_q ? IDX_W'(ADDR_W - 1) : IDX_W'(TOT - 1)));
   assign in_data  = (idx_q >= IDX_W'(ADDR_W));
   assign is_read  = rd_kind_q && in_data;
   assign start    = (st_q == FR_LAUNCH) || ((st_q == FR_RUN) && bit_done && !last_bit);
   assign dq_out   = shreg_q[0];
   assign dq_oe    = (st_q != FR_IDLE) && !is_read;
   assign busy     = (st_q != FR_IDLE);
   assign done     = done_q;
   assign rdata    = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FR_IDLE;
         shreg_q   <= '0;
         idx_q     <= '0;
         rd_kind_q <= 1'b0;
         cmd_q     <= 1'b0;
         done_q    <= 1'b0;
         rx_q      <= '0;
         rdata_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (sample_en) rx_q <= {dq_in, rx_q[DATA_W-1:1]};
         unique case (st_q)
            FR_IDLE: if (req_valid) begin
               shreg_q   <= {req_wdata, req_addr};
               idx_q     <= '0;
               rd_kind_q <= req_read && !req_cmd;
               cmd_q     <= req_cmd;
               st_q      <= FR_LAUNCH;
            end
            FR_LAUNCH: st_q <= FR_RUN;
            FR_RUN: if (bit_done) begin
               if (last_bit) begin
                  st_q   <= FR_IDLE;
                  done_q <= 1'b1;
                  if (rd_kind_q) rdata_q <= rx_q;
               end else begin
                  idx_q   <= idx_q + 1'b1;
                  shreg_q <= shreg_q >> 1;
               end
            end
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   // R9: completion is a single-cycle pulse
   a_r9_done_single : assert property (@(posedge clk) disable iff (!rst_n) done |=> !done)
      else $error("done held longer than one cycle");
   // R9: done is only seen when the master is free again
   a_r9_done_free : assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy)
      else $error("done while busy");
   // R4: a command never advances into the data phase
   a_r4_cmd_short : assert property (@(posedge clk) disable iff (!rst_n) (busy && cmd_q) |-> !in_data)
      else $error("command entered data phase");
   // R5: rdata moves only when a read completes
   a_r5_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n) !done |=> (done || $stable(rdata)))
      else $error("rdata changed outside completion");

endmodule

// File: rtl/srm_serial_master.sv
module srm_serial_master
   import srm_pkg::*;
#(
   parameter int unsigned      ADDR_W   = 4,
   parameter int unsigned      DATA_W   = 8,
   parameter longint unsigned  CLK_HZ   = 64'd50_000_000,
   parameter longint unsigned  PULSE_NS = 64'd1000,
   parameter longint unsigned  GAP_NS   = 64'd1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              req_read,
   input  logic              req_cmd,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              cs_n,
   output logic              wr_n,
   output logic              rd_n,
   output logic              dq_out,
   output logic              dq_oe,
   input  logic              dq_in
);

   localparam int unsigned N_PULSE = ns_to_cycles(CLK_HZ, PULSE_NS);
   localparam int unsigned N_GAP   = ns_to_cycles(CLK_HZ, GAP_NS);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be at least 1");
      end
      if (CLK_HZ == 0) begin : g_bad_clock
         $error("CLK_HZ must be non-zero");
      end
   endgenerate

   logic start, is_read, bit_done, sample_en;

   srm_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_read  (req_read),
      .req_cmd   (req_cmd),
      .dq_in     (dq_in),
      .bit_done  (bit_done),
      .sample_en (sample_en),
      .start     (start),
      .is_read   (is_read),
      .dq_out    (dq_out),
      .dq_oe     (dq_oe),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata)
   );

   srm_bit_phy #(.N_PULSE(N_PULSE), .N_GAP(N_GAP)) u_phy (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_read   (is_read),
      .bit_done  (bit_done),
      .sample_en (sample_en),
      .cs_n      (cs_n),
      .wr_n      (wr_n),
      .rd_n      (rd_n)
   );

   // R1: lines idle high and the wire is released whenever no access runs
   a_r1_idle_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (cs_n && wr_n && rd_n && !dq_oe))
      else $error("pins active while idle");
   // R7: the wire is never driven during a read strobe
   a_r7_oe_off_read : assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !dq_oe)
      else $error("driving during read strobe");
   // R6: the wire is driven during a write strobe
   a_r6_oe_on_write : assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> dq_oe)
      else $error("write strobe with wire released");
   // R6: the written value holds for the whole strobe
   a_r6_data_stable : assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_n && $past(!wr_n)) |-> $stable(dq_out))
      else $error("data changed under write strobe");

endmodule

// File: tb/sim_srm_serial_master.sv
`timescale 1ns/1ps
module sim_srm_serial_master;

   // 200 MHz: 23 ns -> 4.6 -> 5 cycles, 12 ns -> 2.4 -> 3 cycles (rounded up)
   localparam int NP = 5;
   localparam int NG = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [3:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       req_read = 1'b0;
   logic       req_cmd = 1'b0;
   logic       busy, done, cs_n, wr_n, rd_n, dq_out, dq_oe;
   logic [7:0] rdata;
   logic       dq_in = 1'b0;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // monitor state
   int          nwr, nrd, wlow, rlow, cshi;
   bit          mon_first;
   logic [11:0] wcap;
   logic [7:0]  rd_src;
   logic        wbit;
   logic        pcs = 1'b1, pwr = 1'b1, prd = 1'b1;

   always #2.5 clk = ~clk;

   srm_serial_master #(
      .ADDR_W(4), .DATA_W(8),
      .CLK_HZ(64'd200_000_000), .PULSE_NS(64'd23), .GAP_NS(64'd12)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_read(req_read), .req_cmd(req_cmd),
      .busy(busy), .done(done), .rdata(rdata), .cs_n(cs_n), .wr_n(wr_n),
      .rd_n(rd_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // pin monitor and slave model, sampled on falling edges
   always @(negedge clk) begin
      if (rst_n) begin
         if (pcs && !cs_n) begin
            if (!mon_first) chk(cshi == NG + 1, "R8", "select high time between bits", cshi, NG + 1);
            mon_first = 1'b0;
            cshi = 0;
         end
         if (cs_n) cshi++;
         if (pwr && !wr_n) begin
            chk(pcs && !cs_n, "R6", "select falls with write strobe", cs_n, 0);
            chk(dq_oe, "R6", "wire driven at write strobe", dq_oe, 1);
            if (nwr < 12) wcap[nwr] = dq_out;
            wbit = dq_out;
            wlow = 0;
         end
         if (!wr_n) begin
            wlow++;
            if (dq_out != wbit) chk(1'b0, "R6", "data stable under write strobe", dq_out, wbit);
         end
         if (!pwr && wr_n) begin
            chk(wlow == NP, "R10", "write strobe width", wlow, NP);
            chk(!cs_n, "R6", "select held after write strobe rises", cs_n, 0);
            nwr++;
         end
         if (prd && !rd_n) begin
            chk(pcs && !cs_n, "R7", "select falls with read strobe", cs_n, 0);
            rlow = 0;
         end
         if (!rd_n) begin
            rlow++;
            if (dq_oe) chk(1'b0, "R7", "wire released during read", dq_oe, 0);
            // correct bit only in the cycle before the intended sample edge
            if (nrd < 8) dq_in = (rlow == NP) ? rd_src[nrd] : ~rd_src[nrd];
         end else begin
            dq_in = 1'b0;
         end
         if (!prd && rd_n) begin
            chk(rlow == 2 * NP, "R7", "read strobe width", rlow, 2 * NP);
            chk(cs_n, "R7", "select rises with read strobe", cs_n, 1);
            nrd++;
         end
         pcs = cs_n;
         pwr = wr_n;
         prd = rd_n;
      end
   end

   task automatic xfer(input logic [3:0] a, input logic [7:0] d, input bit rd,
                       input bit cmd, input logic [7:0] rbyte, input bit intrude);
      int t;
      while (busy) @(negedge clk);
      nwr = 0; nrd = 0; wcap = '0; rd_src = rbyte; mon_first = 1'b1;
      req_addr = a; req_wdata = d; req_read = rd; req_cmd = cmd; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (intrude) begin
         repeat (10) @(negedge clk);
         req_addr = ~a; req_wdata = ~d; req_read = 1'b1; req_cmd = 1'b0; req_valid = 1'b1;
         repeat (4) @(negedge clk);
         req_valid = 1'b0;
      end
      t = 0;
      while (!done && t < 5000) begin @(negedge clk); t++; end
      chk(done, "R9", "done pulse seen", done, 1);
      chk(!busy, "R9", "busy low during done", busy, 0);
      @(negedge clk);
      chk(!done, "R9", "done lasts one cycle", done, 0);
   endtask

   task automatic t_reset();
      chk(cs_n && wr_n && rd_n, "R1", "lines high after reset", {cs_n, wr_n, rd_n}, 3'b111);
      chk(!dq_oe, "R1", "wire released after reset", dq_oe, 0);
      chk(!busy && !done, "R1", "busy/done low after reset", {busy, done}, 0);
   endtask

   task automatic t_write(input logic [3:0] a, input logic [7:0] d, input logic [7:0] keep_rd);
      xfer(a, d, 1'b0, 1'b0, 8'h00, 1'b0);
      chk(nwr == 12, "R3", "write strobe count", nwr, 12);
      chk(nrd == 0, "R3", "no read strobe on write", nrd, 0);
      chk(wcap[3:0] == a, "R2", "address bits LSB first", wcap[3:0], a);
      chk(wcap[11:4] == d, "R3", "data bits LSB first", wcap[11:4], d);
      chk(rdata == keep_rd, "R5", "rdata unchanged by write", rdata, keep_rd);
      chk(cs_n && !dq_oe, "R1", "idle after write", {cs_n, dq_oe}, 2'b10);
   endtask

   task automatic t_cmd(input logic [3:0] a);
      xfer(a, 8'hFF, 1'b1, 1'b1, 8'hFF, 1'b0);
      chk(nwr == 4, "R4", "command strobe count", nwr, 4);
      chk(nrd == 0, "R4", "command has no read strobe", nrd, 0);
      chk(wcap[3:0] == a, "R2", "command address bits", wcap[3:0], a);
   endtask

   task automatic t_read(input logic [3:0] a, input logic [7:0] b);
      xfer(a, 8'h00, 1'b1, 1'b0, b, 1'b0);
      chk(nwr == 4, "R5", "read address strobes", nwr, 4);
      chk(wcap[3:0] == a, "R2", "read address bits", wcap[3:0], a);
      chk(nrd == 8, "R5", "read strobe count", nrd, 8);
      chk(rdata == b, "R5", "read byte assembly", rdata, b);
   endtask

   task automatic t_ignore(input logic [7:0] keep_rd);
      int n_before;
      xfer(4'h6, 8'h3C, 1'b0, 1'b0, 8'h00, 1'b1);
      chk(nwr == 12 && nrd == 0, "R9", "busy request ignored: strobes", {nwr[7:0], nrd[7:0]}, 16'h0C00);
      chk(wcap == 12'h3C6, "R9", "busy request ignored: bit stream", wcap, 12'h3C6);
      n_before = nwr;
      repeat (40) @(negedge clk);
      chk(nwr == n_before && cs_n && !busy, "R9", "no access after ignored request", nwr, n_before);
      chk(rdata == keep_rd, "R5", "rdata kept", rdata, keep_rd);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write(4'h5, 8'hA6, 8'h00);
      t_write(4'hA, 8'h01, 8'h00);
      t_cmd(4'hE);
      t_read(4'h3, 8'h5C);
      t_read(4'hC, 8'hA1);
      t_ignore(8'hA1);
      t_write(4'h0, 8'hFF, 8'hA1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule